// File: doc/BRIEF.md
# External Bus Stretch-and-Wait Sequencer

This block runs a single read or write to external data memory for a small 8-bit controller core. The core accepts a request only while the block is idle. The request is a one-cycle start pulse together with a direction, a 16-bit address, a write byte and a stretch count. Every machine cycle of the access is four clock states long, named C1, C2, C3 and C4.

The first machine cycle is the address cycle. In it the low address byte goes out on the shared address/data port, where the address latch enable captures it, and the high address byte goes out on its own port. Data machine cycles follow. Their number is at least the stretch count plus one. During the data cycles the read or write strobe is held low without a break. A write drives its byte onto the shared port during these cycles. A read takes the port's value on the edge where the strobe rises, and a one-cycle done pulse follows.

An external wait input can lengthen the access without limit. The input passes through a two-flop synchronizer and is examined in C3 of each data machine cycle. Each high sample adds one more machine cycle. This only happens when a wait-enable bit is set. That bit can only be written while an unlock-valid input is high, which stands in for a timed-access protection sequence.

Top module: `xbw_top`

## Requirements
- R1: During and right after reset the block is idle: rd_n_o and wr_n_o are high, ale_o, ad_oe_o and done_o are low, a_hi_o is zero.
- R2: In the address machine cycle, ale_o is high only in C1. Throughout the cycle, ad_out_o carries address bits 7:0 with ad_oe_o high and a_hi_o carries address bits 15:8. a_hi_o keeps the address high byte until the access ends.
- R3: With no wait cycles added, an access accepted on clock edge E puts done_o high in the cycle that follows edge E + 4*(S+2), where S is the latched stretch count.
- R4: The strobe for the latched direction (rd_n_o for a read, wr_n_o for a write) is low from C1 of the first data machine cycle through C4 of the last one. It falls once and rises once per access, and the other strobe stays high.
- R5: During the data cycles of a write, ad_oe_o is high and ad_out_o carries the write byte. During the data cycles of a read, ad_oe_o is low.
- R6: On the edge that ends the last C4 of a read, rdata_o takes the value of ad_in_i. rdata_o keeps that value until a later read finishes.
- R7: When waits are enabled, wait_i is synchronized by two flops and sampled in C3 of every data machine cycle. Each high sample adds exactly one machine cycle, with no upper bound. The access ends at the C4 in which no added cycle remains.
- R8: When waits are disabled, wait_i has no effect on the length of an access.
- R9: The wait-enable bit takes the value of cfg_wait_en_i only on an edge where cfg_we_i and unlock_ok_i are both high. Otherwise it keeps its value. It resets to 0.
- R10: start_i is ignored while an access is in progress. The latched address, direction and length are unaffected.
- R11: done_o is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access request, taken only when idle |
| is_write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write byte |
| stretch_i | input | 3 | Stretch count S |
| cfg_we_i | input | 1 | Write strobe for the wait-enable bit |
| cfg_wait_en_i | input | 1 | New value for the wait-enable bit |
| unlock_ok_i | input | 1 | Protection unlock valid |
| wait_i | input | 1 | Asynchronous wait request, active high |
| ad_in_i | input | 8 | Shared port input value |
| ad_out_o | output | 8 | Shared port output value |
| ad_oe_o | output | 1 | Shared port output enable |
| a_hi_o | output | 8 | High address byte |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rdata_o | output | 8 | Captured read byte |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data and a 3-bit stretch count. With these, every stretch value from 0 up to the maximum of 7 can be reached. The bench uses both ends of that range as well as values in between. The bench holds wait_i high for tens of cycles so that the wait counter runs far past the stretch count, which shows the extension has no upper bound. It also toggles the protected enable bit with and without unlock.

// File: rtl/xbw_pkg.sv
package xbw_pkg;

  typedef enum logic [1:0] {
    PH_C1 = 2'd0,
    PH_C2 = 2'd1,
    PH_C3 = 2'd2,
    PH_C4 = 2'd3
  } xbw_phase_t;

  // Machine cycles still owed after the current one, once its wait sample is known.
  function automatic int owed_after(input int owed_now, input logic wait_hit);
    return owed_now + (wait_hit ? 1 : 0) - 1;
  endfunction

  // True when the current data machine cycle is the last one.
  function automatic logic is_last_mc(input int owed_now, input logic wait_hit);
    return (owed_now + (wait_hit ? 1 : 0)) == 0;
  endfunction

endpackage

// File: rtl/xbw_sync.sv
module xbw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xbw_cfg.sv
module xbw_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  logic val_i,
  input  logic unlock_i,
  output logic wait_en_o
);
  logic en_q;
  logic take_w;

  assign take_w = we_i & unlock_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (take_w) en_q <= val_i;
  end

  assign wait_en_o = en_q;
endmodule

// File: rtl/xbw_seq.sv
module xbw_seq
  import xbw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int STRETCH_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 is_write_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [STRETCH_W-1:0] stretch_i,
  input  logic                 wait_s_i,
  input  logic                 wait_en_i,
  output logic                 busy_o,
  output logic                 in_data_o,
  output xbw_phase_t           phase_o,
  output logic                 wr_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    wd_o,
  output logic                 accept_o,
  output logic                 last_c4_o
);
  logic                 busy_q, data_q, wr_q, hit_q;
  xbw_phase_t           ph_q;
  logic [STRETCH_W-1:0] owed_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wd_q;
  logic                 sample_w, hit_now_w;

  assign accept_o  = start_i & ~busy_q;
  assign sample_w  = busy_q & data_q & (ph_q == PH_C3);
  assign hit_now_w = sample_w & wait_en_i & wait_s_i;
  assign last_c4_o = busy_q & data_q & (ph_q == PH_C4) &
                     is_last_mc(int'(owed_q), hit_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      data_q <= 1'b0;
      ph_q   <= PH_C1;
      owed_q <= '0;
      hit_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      data_q <= 1'b0;
      ph_q   <= PH_C1;
      owed_q <= stretch_i;
      hit_q  <= 1'b0;
      wr_q   <= is_write_i;
      addr_q <= addr_i;
      wd_q   <= wdata_i;
    end else if (busy_q) begin
      ph_q <= xbw_phase_t'(ph_q + 2'd1);
      if (sample_w) hit_q <= hit_now_w;
      if (ph_q == PH_C4) begin
        hit_q <= 1'b0;
        if (!data_q) begin
          data_q <= 1'b1;
        end else if (last_c4_o) begin
          busy_q <= 1'b0;
          data_q <= 1'b0;
        end else begin
          owed_q <= STRETCH_W'(owed_after(int'(owed_q), hit_q));
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign in_data_o = data_q;
  assign phase_o   = ph_q;
  assign wr_o      = wr_q;
  assign addr_o    = addr_q;
  assign wd_o      = wd_q;
endmodule

// File: rtl/xbw_pins.sv
module xbw_pins
  import xbw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy_i,
  input  logic                     in_data_i,
  input  xbw_phase_t               phase_i,
  input  logic                     wr_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wd_i,
  input  logic                     last_c4_i,
  input  logic [DATA_W-1:0]        ad_in_i,
  output logic [DATA_W-1:0]        ad_out_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] a_hi_o,
  output logic                     ale_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic addr_mc_w, data_mc_w;
  logic [DATA_W-1:0] rdata_q;
  logic done_q;

  assign addr_mc_w = busy_i & ~in_data_i;
  assign data_mc_w = busy_i & in_data_i;

  always_comb begin
    ad_out_o = '0;
    ad_oe_o  = 1'b0;
    if (addr_mc_w) begin
      ad_out_o = addr_i[DATA_W-1:0];
      ad_oe_o  = 1'b1;
    end else if (data_mc_w && wr_i) begin
      ad_out_o = wd_i;
      ad_oe_o  = 1'b1;
    end
  end

  assign a_hi_o = busy_i ? addr_i[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
  assign ale_o  = addr_mc_w & (phase_i == PH_C1);
  assign rd_n_o = ~(data_mc_w & ~wr_i);
  assign wr_n_o = ~(data_mc_w & wr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_c4_i;
      if (last_c4_i && !wr_i) rdata_q <= ad_in_i;
    end
  end

  assign rdata_o = rdata_q;
  assign done_o  = done_q;
endmodule

// File: rtl/xbw_top.sv
module xbw_top
  import xbw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int STRETCH_W   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     is_write_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [STRETCH_W-1:0]     stretch_i,
  input  logic                     cfg_we_i,
  input  logic                     cfg_wait_en_i,
  input  logic                     unlock_ok_i,
  input  logic                     wait_i,
  input  logic [DATA_W-1:0]        ad_in_i,
  output logic [DATA_W-1:0]        ad_out_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] a_hi_o,
  output logic                     ale_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     done_o
);
  logic              wait_s_w, wait_en_w;
  logic              busy_w, in_data_w, wr_w, accept_w, last_c4_w;
  xbw_phase_t        phase_w;
  logic [ADDR_W-1:0] addr_w;
  logic [DATA_W-1:0] wd_w;

  xbw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(wait_i), .q_o(wait_s_w)
  );

  xbw_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .val_i(cfg_wait_en_i),
    .unlock_i(unlock_ok_i), .wait_en_o(wait_en_w)
  );

  xbw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRETCH_W(STRETCH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .stretch_i(stretch_i),
    .wait_s_i(wait_s_w), .wait_en_i(wait_en_w),
    .busy_o(busy_w), .in_data_o(in_data_w), .phase_o(phase_w), .wr_o(wr_w),
    .addr_o(addr_w), .wd_o(wd_w), .accept_o(accept_w), .last_c4_o(last_c4_w)
  );

  xbw_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_w), .in_data_i(in_data_w),
    .phase_i(phase_w), .wr_i(wr_w), .addr_i(addr_w), .wd_i(wd_w),
    .last_c4_i(last_c4_w), .ad_in_i(ad_in_i),
    .ad_out_o(ad_out_o), .ad_oe_o(ad_oe_o), .a_hi_o(a_hi_o), .ale_o(ale_o),
    .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .rdata_o(rdata_o), .done_o(done_o)
  );
endmodule

// File: rtl/xbw_chk.sv
module xbw_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              last_c4,
  input logic              wait_en,
  input logic              cfg_we,
  input logic              unlock,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              done,
  input logic [DATA_W-1:0] rdata
);
  // R4: never both strobes low
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R2: latch enable never overlaps a strobe
  a_r2_ale_apart: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n));

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: the last C4 is followed by done
  a_r3_done_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    last_c4 |=> done);

  // R6: read byte only moves with done
  a_r6_rdata_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

  // R9: locked bit holds without unlock
  a_r9_locked_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && unlock) |=> $stable(wait_en));

  // R10: a start during an access does not end it
  a_r10_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_c4) |=> busy);
endmodule

bind xbw_top xbw_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start_i), .busy(busy_w),
  .last_c4(last_c4_w), .wait_en(wait_en_w), .cfg_we(cfg_we_i),
  .unlock(unlock_ok_i), .ale(ale_o), .rd_n(rd_n_o), .wr_n(wr_n_o),
  .done(done_o), .rdata(rdata_o)
);

// File: tb/xbw_top_tb.sv
`timescale 1ns/1ps
module xbw_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, is_write_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [2:0]  stretch_i = '0;
  logic cfg_we_i = 1'b0, cfg_wait_en_i = 1'b0, unlock_ok_i = 1'b0;
  logic wait_i = 1'b0;
  logic [7:0] ad_in_i = 8'h11;
  logic [7:0] ad_out_o, a_hi_o, rdata_o;
  logic ad_oe_o, ale_o, rd_n_o, wr_n_o, done_o;

  int total = 0;
  int bad = 0;
  string scen = "R3";

  always #2 clk = ~clk;  // 250 MHz

  xbw_top u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_write_i(is_write_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .stretch_i(stretch_i),
    .cfg_we_i(cfg_we_i), .cfg_wait_en_i(cfg_wait_en_i), .unlock_ok_i(unlock_ok_i),
    .wait_i(wait_i), .ad_in_i(ad_in_i), .ad_out_o(ad_out_o), .ad_oe_o(ad_oe_o),
    .a_hi_o(a_hi_o), .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
    .rdata_o(rdata_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Reference model: elapsed-cycle view of one access.
  bit m_busy = 0, m_wr = 0, m_wen = 0, m_done = 0;
  int m_cyc = 0, m_s = 0, m_extra = 0;
  int m_addr = 0, m_wd = 0, m_rdata = 0;
  bit q_sync[$];

  initial begin q_sync.push_back(1'b0); q_sync.push_back(1'b0); end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_wen = 0; m_rdata = 0; m_cyc = 0;
      q_sync[0] = 1'b0; q_sync[1] = 1'b0;
    end else begin
      int mc, ph;
      mc = m_cyc / 4; ph = m_cyc % 4;
      m_done = 0;
      if (m_busy) begin
        if (mc >= 1 && ph == 2 && m_wen && q_sync[1]) m_extra++;
        if (mc >= 1 && ph == 3 && (mc - 1) == m_s + m_extra) begin
          m_busy = 0; m_done = 1;
          if (!m_wr) m_rdata = int'(ad_in_i);
        end else m_cyc++;
      end else if (start_i) begin
        m_busy = 1; m_cyc = 0; m_extra = 0; m_wr = is_write_i;
        m_s = int'(stretch_i); m_addr = int'(addr_i); m_wd = int'(wdata_i);
      end
      if (cfg_we_i && unlock_ok_i) m_wen = cfg_wait_en_i;
      void'(q_sync.pop_back());
      q_sync.push_front(wait_i);
    end
  end

  always @(negedge clk) begin
    int mc, ph;
    bit e_oe;
    mc = m_cyc / 4; ph = m_cyc % 4;
    e_oe = m_busy && (mc == 0 || m_wr);
    chk("R2 ale", int'(ale_o), int'(m_busy && mc == 0 && ph == 0));
    chk("R2 a_hi", int'(a_hi_o), m_busy ? (m_addr >> 8) : 0);
    chk("R5 ad_oe", int'(ad_oe_o), int'(e_oe));
    if (e_oe) chk("R5 ad_out", int'(ad_out_o), (mc == 0) ? (m_addr & 255) : m_wd);
    chk("R4 rd_n", int'(rd_n_o), int'(!(m_busy && mc >= 1 && !m_wr)));
    chk("R4 wr_n", int'(wr_n_o), int'(!(m_busy && mc >= 1 && m_wr)));
    chk({scen, " done"}, int'(done_o), int'(m_done));
    chk("R6 rdata", int'(rdata_o), m_rdata);
    ad_in_i <= ad_in_i + 8'd37;
  end

  task automatic access(input bit wr, input int addr, input int wd, input int s,
                        input int wlen, input int again_at, output int k);
    @(negedge clk);
    is_write_i = wr; addr_i = addr[15:0]; wdata_i = wd[7:0]; stretch_i = s[2:0];
    start_i = 1'b1;
    if (wlen > 0) wait_i = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      start_i = (k == again_at);
      if (k == again_at) begin addr_i = 16'hDEAD; stretch_i = 3'd7; is_write_i = ~wr; end
      if (k == wlen) wait_i = 1'b0;
    end while (!done_o && k < 2000);
    start_i = 1'b0; wait_i = 1'b0;
    @(negedge clk);
    chk("R11 done one cycle", int'(done_o), 0);
  endtask

  task automatic set_wen(input bit val, input bit unl);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_wait_en_i = val; unlock_ok_i = unl;
    @(negedge clk);
    cfg_we_i = 1'b0; unlock_ok_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    repeat (4) @(negedge clk);
    chk("R1 rd_n in reset", int'(rd_n_o), 1);
    chk("R1 done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_n idle", int'(wr_n_o), 1);
    chk("R1 ale idle", int'(ale_o), 0);
    chk("R1 oe idle", int'(ad_oe_o), 0);
    chk("R1 a_hi idle", int'(a_hi_o), 0);

    scen = "R8";   // waits disabled: wait_i held high has no effect
    access(0, 'h1234, 0, 0, 1000, 0, k);
    chk("R8 length ignores wait", k, 4 * 2 + 1);

    scen = "R3";
    access(1, 'hA55A, 'hC3, 2, 0, 0, k);
    chk("R3 write S=2 length", k, 4 * 4 + 1);
    access(0, 'h0F0F, 0, 7, 0, 0, k);
    chk("R3 read S=7 length", k, 4 * 9 + 1);

    scen = "R9";   // write without unlock is dropped
    set_wen(1, 0);
    access(0, 'h4242, 0, 1, 1000, 0, k);
    chk("R9 locked bit unchanged", k, 4 * 3 + 1);
    set_wen(1, 1);

    scen = "R7";
    access(0, 'h7001, 0, 1, 20, 0, k);
    chk("R7 lengthened", int'(k > 13), 1);
    chk("R7 whole cycles added", (k - 13) % 4, 0);
    access(1, 'h7002, 'h5A, 0, 60, 0, k);
    chk("R7 unbounded extension", int'(k >= 9 + 40), 1);
    chk("R7 whole cycles added long", (k - 9) % 4, 0);
    access(0, 'h7003, 0, 3, 0, 0, k);
    chk("R7 no wait no extension", k, 4 * 5 + 1);

    scen = "R10";  // second start mid-access is ignored
    access(0, 'h3C3C, 0, 2, 0, 6, k);
    chk("R10 length unchanged", k, 4 * 4 + 1);
    repeat (3) @(negedge clk);
    chk("R10 stays idle rd_n", int'(rd_n_o), 1);
    chk("R10 stays idle wr_n", int'(wr_n_o), 1);
    chk("R10 stays idle a_hi", int'(a_hi_o), 0);

    scen = "R8";
    set_wen(0, 1);
    access(1, 'hBEEF, 'h99, 0, 1000, 0, k);
    chk("R8 disabled again", k, 4 * 2 + 1);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule